// File: doc/BRIEF.md
# Paired Register Rename Unit

This unit translates the register names of one instruction per cycle from the logical space into a physical space. Physical registers are handed out as even/odd pairs. Each instruction may have up to two sources and one destination. A map table gives the current physical number of every logical register. A linked free list holds the unused pairs. A per-pair status table records three bits and one tag:

- **busy**: the value of the pair has not been written back yet.
- **in-window**: the pair has a producer that is still in flight.
- **error**: the pair's producer faulted.
- **owner**: the tag of the instruction that writes the pair.

For each request, the unit does the following:

- It reads both sources through the map.
- For every source whose producer is still in flight, it reports a dependency and the producer's tag.
- It gives a general destination a fresh pair and reports the pair that destination occupied before, so that the pair can be freed later.

The request is accepted or refused as a whole. The unit refuses it in three cases:

- a source carries the error mark;
- no free pair is left;
- the destination is a special register whose previous write is still busy.

On refusal, no map, status or free-list entry changes. All results are registered and appear one cycle after the request.

Two inputs stand in for the back end of the pipeline:

- A write-back input clears busy and in-window on a pair and records whether its producer faulted.
- A release input returns a pair to the free list when the superseded mapping retires.

Top module: `pair_rename`

## Requirements
- R1: After reset, logical register r maps to physical 2r + (r mod 2), so it sits in pair r. No pair is busy, in-window or in error. The free list holds pairs NUM_LOG to NUM_PAIR-1 and hands them out in ascending order. All outputs are zero.
- R2: A non-zero source returns its current map entry on out_psrc. Source register 0 returns physical 0 and never reports a dependency.
- R3: A non-zero source whose pair is in-window sets its dep bit, and its own output carries that pair's owner tag. Otherwise dep and own are 0.
- R4: When req_is_store is 1, the second source never reports a dependency, although it is still translated.
- R5: A general destination (1 to NUM_LOG-SPEC_NUM-1) takes the head pair p of the free list and gets physical 2p + (dst mod 2). That pair becomes busy and in-window with owner req_tag, and the map is updated. out_old_vld is 1 and out_old_pair carries the pair the destination held before.
- R6: If a general destination finds the free list empty, the rename fails with code 2. No state changes.
- R7: If either non-zero source sits in a pair marked error, the rename fails with code 1. No state changes. This check has priority over codes 2 and 3.
- R8: The top SPEC_NUM logical registers are special and are never renamed; out_pdst is their fixed map entry and out_old_vld is 0. The rename fails with code 3 while that pair is busy. Otherwise the pair becomes busy and in-window, with owner req_tag.
- R9: A write-back on a pair clears its busy and in-window bits and sets its error bit to wb_err. It takes effect for requests in the following cycle.
- R10: A release pushes the pair onto the head of the free list and clears its status. The next allocation returns that pair (last in, first out). When a release and an allocation fall in the same cycle, the allocation takes the old head.
- R11: Destination register 0 allocates nothing: out_pdst is 0 and out_old_vld is 0.
- R12: Results appear one cycle after the request. out_ok is 1 only with code 0. With no request, every output is 0. The codes are: 0 success or idle, 1 source error, 2 no free pair, 3 special busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Rename request this cycle |
| req_src1 | input | LW | First logical source |
| req_src2 | input | LW | Second logical source (store data for stores) |
| req_dst | input | LW | Logical destination |
| req_is_store | input | 1 | Request is a store |
| req_tag | input | TAG_W | Tag of the renaming instruction |
| wb_valid | input | 1 | Write-back of a pair |
| wb_pair | input | PAIR_W | Pair being written back |
| wb_err | input | 1 | Producer of that pair faulted |
| rel_valid | input | 1 | Return a pair to the free list |
| rel_pair | input | PAIR_W | Pair being returned |
| out_ok | output | 1 | Rename succeeded |
| out_code | output | 2 | Failure code |
| out_psrc1 | output | PHYS_W | Physical first source |
| out_dep1 | output | 1 | First source waits on a producer |
| out_own1 | output | TAG_W | Producer tag of first source |
| out_psrc2 | output | PHYS_W | Physical second source |
| out_dep2 | output | 1 | Second source waits on a producer |
| out_own2 | output | TAG_W | Producer tag of second source |
| out_pdst | output | PHYS_W | Physical destination |
| out_old_vld | output | 1 | A previous mapping is to be freed later |
| out_old_pair | output | PAIR_W | Pair of the previous mapping |

## Verification
Each kind of corrupted internal state shows up at the ports in its own way:

- **Map table entry**: the next request that names that logical register as a source shows the wrong out_psrc, one cycle later.
- **Free list**: the next allocation returns an unexpected or repeated pair, seen on out_pdst.
- **Status bit**: a wrong dep flag or owner tag appears, or a spurious failure code, on the next request touching that pair.

A reference model in the bench tracks the map, status and free list. Every cycle, it compares the full registered result vector, so any such divergence is reported within one request of its first use.

// File: rtl/pr_pkg.sv
`timescale 1ns/1ps
package pr_pkg;
  typedef enum logic [1:0] {
    RN_OK        = 2'd0,
    RN_SRC_ERR   = 2'd1,
    RN_NO_FREE   = 2'd2,
    RN_SPEC_BUSY = 2'd3
  } rn_code_e;
endpackage

// File: rtl/pr_freelist.sv
`timescale 1ns/1ps
// Linked list of free physical pairs, popped and pushed at the head.
module pr_freelist #(
  parameter int NUM_PAIR   = 48,
  parameter int FIRST_FREE = 32,
  localparam int PAIR_W    = $clog2(NUM_PAIR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  input  logic              push,
  input  logic [PAIR_W-1:0] push_pair,
  output logic [PAIR_W-1:0] head_pair,
  output logic              empty
);
  // each link holds {valid, next pair}
  logic [PAIR_W:0] link_q [NUM_PAIR];
  logic [PAIR_W:0] head_q;

  assign head_pair = head_q[PAIR_W-1:0];
  assign empty     = ~head_q[PAIR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAIR; i++) begin
        link_q[i] <= (i < NUM_PAIR - 1) ? {1'b1, PAIR_W'(i + 1)} : '0;
      end
      head_q <= (FIRST_FREE < NUM_PAIR) ? {1'b1, PAIR_W'(FIRST_FREE)} : '0;
    end else begin
      if (pop && push) begin
        link_q[push_pair] <= link_q[head_pair];
        head_q            <= {1'b1, push_pair};
      end else if (pop) begin
        head_q <= link_q[head_pair];
      end else if (push) begin
        link_q[push_pair] <= head_q;
        head_q            <= {1'b1, push_pair};
      end
    end
  end
endmodule

// File: rtl/pr_maptable.sv
`timescale 1ns/1ps
// Logical-to-physical map with three read ports and one write port.
module pr_maptable #(
  parameter int NUM_LOG = 32,
  parameter int PHYS_W  = 7,
  localparam int LW     = $clog2(NUM_LOG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LW-1:0]     ra_a,
  input  logic [LW-1:0]     ra_b,
  input  logic [LW-1:0]     ra_c,
  output logic [PHYS_W-1:0] rd_a,
  output logic [PHYS_W-1:0] rd_b,
  output logic [PHYS_W-1:0] rd_c,
  input  logic              we,
  input  logic [LW-1:0]     wa,
  input  logic [PHYS_W-1:0] wd
);
  logic [PHYS_W-1:0] map_q [NUM_LOG];

  assign rd_a = map_q[ra_a];
  assign rd_b = map_q[ra_b];
  assign rd_c = map_q[ra_c];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        map_q[i] <= PHYS_W'(2 * i + (i % 2));
      end
    end else if (we) begin
      map_q[wa] <= wd;
    end
  end
endmodule

// File: rtl/pr_pairstat.sv
`timescale 1ns/1ps
// Per-pair status: busy, in-window, error and owner tag.
module pr_pairstat #(
  parameter int NUM_PAIR = 48,
  parameter int TAG_W    = 6,
  localparam int PAIR_W  = $clog2(NUM_PAIR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAIR_W-1:0] q_a,
  input  logic [PAIR_W-1:0] q_b,
  input  logic [PAIR_W-1:0] q_c,
  output logic              inwin_a,
  output logic              err_a,
  output logic [TAG_W-1:0]  own_a,
  output logic              inwin_b,
  output logic              err_b,
  output logic [TAG_W-1:0]  own_b,
  output logic              busy_c,
  input  logic              wb_valid,
  input  logic [PAIR_W-1:0] wb_pair,
  input  logic              wb_err,
  input  logic              rel_valid,
  input  logic [PAIR_W-1:0] rel_pair,
  input  logic              set_valid,
  input  logic [PAIR_W-1:0] set_pair,
  input  logic [TAG_W-1:0]  set_tag
);
  logic [NUM_PAIR-1:0] busy_q, inwin_q, err_q;
  logic [TAG_W-1:0]    own_q [NUM_PAIR];

  assign inwin_a = inwin_q[q_a];
  assign err_a   = err_q[q_a];
  assign own_a   = own_q[q_a];
  assign inwin_b = inwin_q[q_b];
  assign err_b   = err_q[q_b];
  assign own_b   = own_q[q_b];
  assign busy_c  = busy_q[q_c];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      inwin_q <= '0;
      err_q   <= '0;
    end else begin
      if (wb_valid) begin
        busy_q[wb_pair]  <= 1'b0;
        inwin_q[wb_pair] <= 1'b0;
        err_q[wb_pair]   <= wb_err;
      end
      if (rel_valid) begin
        busy_q[rel_pair]  <= 1'b0;
        inwin_q[rel_pair] <= 1'b0;
        err_q[rel_pair]   <= 1'b0;
      end
      if (set_valid) begin
        busy_q[set_pair]  <= 1'b1;
        inwin_q[set_pair] <= 1'b1;
        err_q[set_pair]   <= 1'b0;
      end
    end
  end

  // owner tags carry no reset so they can sit in distributed RAM
  always_ff @(posedge clk) begin
    if (set_valid) own_q[set_pair] <= set_tag;
  end
endmodule

// File: rtl/pair_rename.sv
`timescale 1ns/1ps
module pair_rename #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PAIR = 48,
  parameter int TAG_W    = 6,
  parameter int SPEC_NUM = 2,
  localparam int LW      = $clog2(NUM_LOG),
  localparam int PAIR_W  = $clog2(NUM_PAIR),
  localparam int PHYS_W  = PAIR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LW-1:0]     req_src1,
  input  logic [LW-1:0]     req_src2,
  input  logic [LW-1:0]     req_dst,
  input  logic              req_is_store,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              wb_valid,
  input  logic [PAIR_W-1:0] wb_pair,
  input  logic              wb_err,
  input  logic              rel_valid,
  input  logic [PAIR_W-1:0] rel_pair,
  output logic              out_ok,
  output logic [1:0]        out_code,
  output logic [PHYS_W-1:0] out_psrc1,
  output logic              out_dep1,
  output logic [TAG_W-1:0]  out_own1,
  output logic [PHYS_W-1:0] out_psrc2,
  output logic              out_dep2,
  output logic [TAG_W-1:0]  out_own2,
  output logic [PHYS_W-1:0] out_pdst,
  output logic              out_old_vld,
  output logic [PAIR_W-1:0] out_old_pair
);
  import pr_pkg::*;

  localparam int SPEC_BASE = NUM_LOG - SPEC_NUM;

  logic [PHYS_W-1:0] map_s1, map_s2, map_d, new_phys;
  logic              inwin1, err1, inwin2, err2, busy_d;
  logic [TAG_W-1:0]  own1, own2;
  logic [PAIR_W-1:0] head_pair;
  logic              fl_empty;
  logic              use1, use2, dst_gen, dst_spec, err_hit, go, pop;
  logic              set_valid;
  logic [PAIR_W-1:0] set_pair;
  rn_code_e          code;
  logic              dep1_n, dep2_n;

  pr_maptable #(.NUM_LOG(NUM_LOG), .PHYS_W(PHYS_W)) u_map (
    .clk(clk), .rst(rst),
    .ra_a(req_src1), .ra_b(req_src2), .ra_c(req_dst),
    .rd_a(map_s1), .rd_b(map_s2), .rd_c(map_d),
    .we(pop), .wa(req_dst), .wd(new_phys)
  );

  pr_pairstat #(.NUM_PAIR(NUM_PAIR), .TAG_W(TAG_W)) u_stat (
    .clk(clk), .rst(rst),
    .q_a(map_s1[PHYS_W-1:1]), .q_b(map_s2[PHYS_W-1:1]), .q_c(map_d[PHYS_W-1:1]),
    .inwin_a(inwin1), .err_a(err1), .own_a(own1),
    .inwin_b(inwin2), .err_b(err2), .own_b(own2),
    .busy_c(busy_d),
    .wb_valid(wb_valid), .wb_pair(wb_pair), .wb_err(wb_err),
    .rel_valid(rel_valid), .rel_pair(rel_pair),
    .set_valid(set_valid), .set_pair(set_pair), .set_tag(req_tag)
  );

  pr_freelist #(.NUM_PAIR(NUM_PAIR), .FIRST_FREE(NUM_LOG)) u_fl (
    .clk(clk), .rst(rst),
    .pop(pop), .push(rel_valid), .push_pair(rel_pair),
    .head_pair(head_pair), .empty(fl_empty)
  );

  // every check is decided before any state is touched
  always_comb begin
    use1     = (req_src1 != '0);
    use2     = (req_src2 != '0);
    dst_spec = (req_dst >= LW'(SPEC_BASE));
    dst_gen  = (req_dst != '0) && !dst_spec;
    err_hit  = (use1 && err1) || (use2 && err2);
    if (err_hit)                 code = RN_SRC_ERR;
    else if (dst_gen && fl_empty) code = RN_NO_FREE;
    else if (dst_spec && busy_d)  code = RN_SPEC_BUSY;
    else                          code = RN_OK;
    go        = req_valid && (code == RN_OK);
    pop       = go && dst_gen;
    new_phys  = {head_pair, req_dst[0]};
    set_valid = go && (dst_gen || dst_spec);
    set_pair  = dst_gen ? head_pair : map_d[PHYS_W-1:1];
    dep1_n    = go && use1 && inwin1;
    dep2_n    = go && use2 && inwin2 && !req_is_store;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ok       <= 1'b0;
      out_code     <= RN_OK;
      out_psrc1    <= '0;
      out_dep1     <= 1'b0;
      out_own1     <= '0;
      out_psrc2    <= '0;
      out_dep2     <= 1'b0;
      out_own2     <= '0;
      out_pdst     <= '0;
      out_old_vld  <= 1'b0;
      out_old_pair <= '0;
    end else begin
      out_ok       <= go;
      out_code     <= req_valid ? code : RN_OK;
      out_psrc1    <= (go && use1) ? map_s1 : '0;
      out_dep1     <= dep1_n;
      out_own1     <= dep1_n ? own1 : '0;
      out_psrc2    <= (go && use2) ? map_s2 : '0;
      out_dep2     <= dep2_n;
      out_own2     <= dep2_n ? own2 : '0;
      out_pdst     <= !go ? '0 : dst_gen ? new_phys : dst_spec ? map_d : '0;
      out_old_vld  <= pop;
      out_old_pair <= pop ? map_d[PHYS_W-1:1] : '0;
    end
  end
endmodule

// File: rtl/pair_rename_chk.sv
`timescale 1ns/1ps
module pair_rename_chk #(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PAIR = 48,
  parameter int SPEC_NUM = 2,
  localparam int LW      = $clog2(NUM_LOG),
  localparam int PHYS_W  = $clog2(NUM_PAIR) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [LW-1:0]     req_src1,
  input logic [LW-1:0]     req_dst,
  input logic              req_is_store,
  input logic              out_ok,
  input logic [1:0]        out_code,
  input logic [PHYS_W-1:0] out_psrc1,
  input logic              out_dep1,
  input logic              out_dep2,
  input logic [PHYS_W-1:0] out_pdst,
  input logic              out_old_vld,
  input logic              fl_empty
);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!out_ok && out_code == 2'd0));

  assert_ok_code_R12: assert property (@(posedge clk) disable iff (rst)
    out_ok |-> out_code == 2'd0);

  assert_src0_nodep_R2: assert property (@(posedge clk) disable iff (rst)
    (out_ok && $past(req_src1) == '0) |-> (!out_dep1 && out_psrc1 == '0));

  assert_store_nodep_R4: assert property (@(posedge clk) disable iff (rst)
    (out_ok && $past(req_is_store)) |-> !out_dep2);

  assert_dst0_noalloc_R11: assert property (@(posedge clk) disable iff (rst)
    (out_ok && $past(req_dst) == '0) |-> (!out_old_vld && out_pdst == '0));

  assert_nofree_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (out_code == 2'd2) |-> $past(fl_empty));

  assert_pair_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (out_ok && out_old_vld) |-> (out_pdst[0] == $past(req_dst[0])));

  assert_spec_noold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_ok && $past(req_dst) >= LW'(NUM_LOG - SPEC_NUM)) |-> !out_old_vld);
endmodule

bind pair_rename pair_rename_chk #(
  .NUM_LOG(NUM_LOG), .NUM_PAIR(NUM_PAIR), .SPEC_NUM(SPEC_NUM)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_src1(req_src1),
  .req_dst(req_dst), .req_is_store(req_is_store), .out_ok(out_ok),
  .out_code(out_code), .out_psrc1(out_psrc1), .out_dep1(out_dep1),
  .out_dep2(out_dep2), .out_pdst(out_pdst), .out_old_vld(out_old_vld),
  .fl_empty(fl_empty)
);

// File: tb/pair_rename_bench.sv
`timescale 1ns/1ps
module pair_rename_bench;
  localparam int NL = 32, NP = 48, TW = 6, SN = 2;
  localparam int SB = NL - SN;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic req_valid, req_is_store, wb_valid, wb_err, rel_valid;
  logic [4:0] req_src1, req_src2, req_dst;
  logic [5:0] req_tag, wb_pair, rel_pair;
  logic out_ok, out_dep1, out_dep2, out_old_vld;
  logic [1:0] out_code;
  logic [6:0] out_psrc1, out_psrc2, out_pdst;
  logic [5:0] out_own1, out_own2, out_old_pair;

  pair_rename #(.NUM_LOG(NL), .NUM_PAIR(NP), .TAG_W(TW), .SPEC_NUM(SN)) u_pair_rename (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src1(req_src1),
    .req_src2(req_src2), .req_dst(req_dst), .req_is_store(req_is_store),
    .req_tag(req_tag), .wb_valid(wb_valid), .wb_pair(wb_pair), .wb_err(wb_err),
    .rel_valid(rel_valid), .rel_pair(rel_pair), .out_ok(out_ok), .out_code(out_code),
    .out_psrc1(out_psrc1), .out_dep1(out_dep1), .out_own1(out_own1),
    .out_psrc2(out_psrc2), .out_dep2(out_dep2), .out_own2(out_own2),
    .out_pdst(out_pdst), .out_old_vld(out_old_vld), .out_old_pair(out_old_pair)
  );

  // reference model
  int mmap [NL];
  bit mbusy [NP], minwin [NP], merr [NP];
  int mown [NP];
  int fl [$];
  int pool [$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [63:0] pk(bit ok, int code, int ps1, bit d1, int o1,
                                     int ps2, bit d2, int o2, int pd, bit ov, int op);
    pk = {19'b0, ok, 2'(code), 7'(ps1), d1, 6'(o1), 7'(ps2), d2, 6'(o2), 7'(pd), ov, 6'(op)};
  endfunction

  function automatic logic [63:0] got_vec();
    got_vec = {19'b0, out_ok, out_code, out_psrc1, out_dep1, out_own1, out_psrc2,
               out_dep2, out_own2, out_pdst, out_old_vld, out_old_pair};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) mmap[i] = 2 * i + (i % 2);
    for (int i = 0; i < NP; i++) begin
      mbusy[i] = 0; minwin[i] = 0; merr[i] = 0; mown[i] = 0;
    end
    fl.delete(); pool.delete();
    for (int i = NL; i < NP; i++) fl.push_back(i);
  endtask

  // one cycle: drive at negedge, sample at the next negedge
  task automatic cyc(string req, bit v, int s1, int s2, int d, bit st, int tag,
                     bit wv, int wp, bit we, bit rv, int rp);
    logic [63:0] exp;
    int code, ps1, ps2, o1, o2, pd, op;
    bit d1, d2, ov, eh, dg, ds;
    req_valid = v; req_src1 = 5'(s1); req_src2 = 5'(s2); req_dst = 5'(d);
    req_is_store = st; req_tag = 6'(tag);
    wb_valid = wv; wb_pair = 6'(wp); wb_err = we; rel_valid = rv; rel_pair = 6'(rp);
    eh = (s1 != 0 && merr[mmap[s1] / 2]) || (s2 != 0 && merr[mmap[s2] / 2]);
    ds = d >= SB;
    dg = d != 0 && !ds;
    code = eh ? 1 : (dg && fl.size() == 0) ? 2 : (ds && mbusy[mmap[d] / 2]) ? 3 : 0;
    exp = '0; pd = 0;
    if (v && code != 0) exp = pk(0, code, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    else if (v) begin
      ps1 = (s1 != 0) ? mmap[s1] : 0;
      ps2 = (s2 != 0) ? mmap[s2] : 0;
      d1 = s1 != 0 && minwin[ps1 / 2];
      d2 = s2 != 0 && minwin[ps2 / 2] && !st;
      o1 = d1 ? mown[ps1 / 2] : 0;
      o2 = d2 ? mown[ps2 / 2] : 0;
      ov = 0; op = 0;
      if (dg) begin
        pd = fl.pop_front() * 2 + (d % 2);
        ov = 1; op = mmap[d] / 2;
        pool.push_back(op);
      end else if (ds) pd = mmap[d];
      exp = pk(1, 0, ps1, d1, o1, ps2, d2, o2, pd, ov, op);
    end
    if (wv) begin mbusy[wp] = 0; minwin[wp] = 0; merr[wp] = we; end
    if (rv) begin mbusy[rp] = 0; minwin[rp] = 0; merr[rp] = 0; fl.push_front(rp); end
    if (v && code == 0 && (dg || ds)) begin
      mbusy[pd / 2] = 1; minwin[pd / 2] = 1; merr[pd / 2] = 0; mown[pd / 2] = tag;
      if (dg) mmap[d] = pd;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, got_vec(), exp);
    req_valid = 0; wb_valid = 0; rel_valid = 0;
  endtask

  task automatic ren(string req, int s1, int s2, int d, bit st, int tag);
    cyc(req, 1, s1, s2, d, st, tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12: watchdog expired, actual hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int rp;
    void'($urandom(32'd4711));
    rst = 1; req_valid = 0; req_src1 = 0; req_src2 = 0; req_dst = 0; req_is_store = 0;
    req_tag = 0; wb_valid = 0; wb_pair = 0; wb_err = 0; rel_valid = 0; rel_pair = 0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset outputs", got_vec(), '0);
    // R1/R2/R5: identity map, first free pair is NL
    ren("R1 R5 first alloc", 5, 7, 9, 0, 3);
    check("R5 direct pdst", 64'(out_pdst), 64'(2 * NL + 1));
    // R3: source on in-window pair reports owner
    ren("R3 dependency", 9, 9, 4, 0, 11);
    // R4: store data source untracked
    ren("R4 store", 9, 9, 0, 1, 12);
    // R2/R11: register zero
    ren("R2 R11 zero regs", 0, 0, 0, 0, 13);
    // R12: idle cycle
    cyc("R12 idle", 0, 9, 9, 9, 0, 1, 0, 0, 0, 0, 0);
    // R9: write-back clears dependency
    cyc("R9 writeback", 0, 0, 0, 0, 0, 0, 1, NL, 0, 0, 0);
    ren("R9 after wb", 9, 0, 0, 0, 14);
    // R7: error source refuses, no state change
    cyc("R9 err wb", 0, 0, 0, 0, 0, 0, 1, NL, 1, 0, 0);
    ren("R7 src error", 9, 4, 6, 0, 15);
    ren("R7 no change", 6, 0, 6, 0, 16);
    cyc("R9 clear err", 0, 0, 0, 0, 0, 0, 1, NL, 0, 0, 0);
    // R8: special register
    ren("R8 special first", 0, 0, SB, 0, 17);
    ren("R8 special busy", 0, 0, SB, 0, 18);
    cyc("R8 spec wb", 0, 0, 0, 0, 0, 0, 1, SB, 0, 0, 0);
    ren("R8 special again", SB, 0, SB, 0, 19);
    // R10: release pushes to head
    rp = pool.pop_front();
    cyc("R10 release", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, rp);
    ren("R10 lifo alloc", 0, 0, 3, 0, 20);
    // R6: exhaust free list
    for (int i = 0; fl.size() > 0; i++) ren("R6 drain", i % 28 + 2, 0, i % 28 + 2, 0, i);
    ren("R6 no free", 0, 0, 2, 0, 21);
    ren("R6 no change", 2, 0, 0, 0, 22);
    // R10: release and allocate in one cycle
    rp = pool.pop_front();
    cyc("R10 same cycle", 1, 0, 0, 7, 0, 23, 0, 0, 0, 1, rp);
    ren("R10 after", 0, 0, 8, 0, 24);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit v, wv, rv, we, st;
      int s1, s2, d, wp, rq;
      v  = ($urandom % 4) != 0;
      s1 = $urandom % NL; s2 = $urandom % NL; d = $urandom % NL;
      st = ($urandom % 4) == 0;
      wv = ($urandom % 3) == 0;
      wp = $urandom % NP;
      we = ($urandom % 16) == 0;
      rv = pool.size() > 0 && ($urandom % 2) == 0;
      rq = 0;
      if (rv) begin
        int k;
        k = $urandom % pool.size();
        rq = pool[k];
        pool.delete(k);
      end
      cyc("R2 R3 R4 R5 R7 R8 R9 R10 random", v, s1, s2, d, st, $urandom % 64,
          wv, wp, we, rv, rq);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule